// File: doc/BRIEF.md
# Delayed Read Request Tracker

This block serves as the target side of a bus bridge for read transactions that cannot finish in one pass. Four kinds of read commands are supported: memory read, memory read line, memory read multiple and I/O read. Each one is handled as a delayed transaction.

On its first attempt, a read is recorded in one of several request slots. The master is told to retry, and the slot sends a single read request upstream, tagged with its slot number. Each time the master repeats the identical request while the upstream read is still outstanding, it gets another retry. When the upstream completion has arrived, the next identical attempt gets the data, and the slot is released.

Each slot is gated by its own enable bit. If no enabled slot is free, a new read is retried and nothing is recorded. If a completed slot is not collected within a fixed number of cycles, its data is discarded.

Top module: `drt_tracker`

## Requirements
- R1: After reset every slot is free, `up_req_valid` is 0 and no response (`resp_retry`, `resp_data_valid`) is given.
- R2: Only the commands I/O read (4'b0010), memory read (4'b0110), memory read multiple (4'b1100) and memory read line (4'b1110) are claimed. Any other code, including configuration read (4'b1010) and interrupt acknowledge (4'b0000), gives neither a retry nor data.
- R3: A claimed read that matches no slot gets `resp_retry` in the same cycle. It is recorded in the lowest-index slot that is both free and enabled.
- R4: A slot whose `slot_en` bit is 0 is never given a new request.
- R5: When no enabled slot is free, a new claimed read gets `resp_retry` and is not recorded, so no upstream read is ever issued for it.
- R6: An attempt matches a slot only when command, address and byte enables all equal the stored values. Any difference makes it a different request.
- R7: Each recorded slot presents exactly one upstream read, carrying its slot index as `up_req_tag` together with the stored command, address and byte enables. The read is held until `up_req_ready`. When several slots wait to issue, the lowest index goes first.
- R8: A matching attempt gets `resp_retry`, and never data, while the slot's upstream read is unsent or outstanding.
- R9: A completion whose `cpl_tag` names a slot that is waiting for it stores `cpl_data` in that slot. A completion for a slot in any other state is ignored.
- R10: A matching attempt on a completed slot gets `resp_data_valid` with the stored data in the same cycle. The slot is free from the next cycle.
- R11: A completed slot left unclaimed for AGE_LIMIT (default 1024) cycles is freed. A later identical attempt is treated as a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | NSLOT | Per-slot allocation enable |
| req_valid | input | 1 | A read attempt is presented this cycle |
| req_cmd | input | 4 | Bus command code of the attempt |
| req_addr | input | ADDR_W | Address of the attempt |
| req_be | input | BE_W | Byte enables of the attempt |
| resp_retry | output | 1 | Tell the master to retry |
| resp_data_valid | output | 1 | Attempt completes with data |
| resp_data | output | DATA_W | Read data for a completing attempt |
| up_req_valid | output | 1 | Upstream read request pending |
| up_req_ready | input | 1 | Upstream accepts the request |
| up_req_tag | output | TAG_W | Slot index of the upstream request |
| up_req_cmd | output | 4 | Command of the upstream request |
| up_req_addr | output | ADDR_W | Address of the upstream request |
| up_req_be | output | BE_W | Byte enables of the upstream request |
| cpl_valid | input | 1 | Upstream completion arrives |
| cpl_tag | input | TAG_W | Slot index of the completion |
| cpl_data | input | DATA_W | Completion data |

## Verification
The assertions check several rules on every cycle:
- no more than one slot matches an attempt;
- retry and data responses never occur together;
- a slot that waits for its completion always answers with retry;
- unsupported commands are never answered;
- a slot only fills while its enable is set;
- a full tracker records nothing;
- each slot goes to waiting after its single issue and to free after a claim;
- an ignored completion leaves the stored data unchanged;
- the age counter stays within its limit.

Only the bench scenarios can show the sequences that need state built up over time. These are:
- the lowest-index choice among enabled slots;
- the exact match on each of command, address and byte enables;
- the data from the right completion being returned;
- the total number of upstream issues;
- the difference between a claim made just before the expiry window closes and one made just after.

// File: rtl/drt_pkg.sv
package drt_pkg;

  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_ISSUE = 2'd1,
    SLOT_WAIT  = 2'd2,
    SLOT_READY = 2'd3
  } slot_state_t;

  localparam logic [3:0] CMD_IO_RD       = 4'b0010;
  localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
  localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
  localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;

  // True for the read commands handled as delayed transactions.
  function automatic logic is_delayed_read(input logic [3:0] cmd);
    return (cmd == CMD_IO_RD) || (cmd == CMD_MEM_RD) ||
           (cmd == CMD_MEM_RD_MULT) || (cmd == CMD_MEM_RD_LINE);
  endfunction

endpackage

// File: rtl/drt_prio.sv
// Lowest-index-first one-hot pick.
module drt_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/drt_slot.sv
// One delayed-read slot: capture, single upstream issue, completion, claim, expiry.
module drt_slot
  import drt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BE_W      = 4,
  parameter int AGE_LIMIT = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              claim,
  input  logic              issue_ack,
  input  logic              cpl_hit,
  input  logic [DATA_W-1:0] cpl_data,
  input  logic [3:0]        probe_cmd,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic [BE_W-1:0]   probe_be,
  output logic              busy,
  output logic              want_issue,
  output logic              ready,
  output logic              match,
  output logic [3:0]        st_cmd,
  output logic [ADDR_W-1:0] st_addr,
  output logic [BE_W-1:0]   st_be,
  output logic [DATA_W-1:0] st_data
);
  localparam int AGE_W = $clog2(AGE_LIMIT + 1);

  slot_state_t       state_q;
  logic [AGE_W-1:0]  age_q;
  logic              expire;

  assign busy       = (state_q != SLOT_FREE);
  assign want_issue = (state_q == SLOT_ISSUE);
  assign ready      = (state_q == SLOT_READY);
  assign match      = busy && (probe_cmd == st_cmd) &&
                      (probe_addr == st_addr) && (probe_be == st_be);
  assign expire     = ready && !claim && (age_q == AGE_W'(AGE_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SLOT_FREE;
      age_q   <= '0;
      st_cmd  <= '0;
      st_addr <= '0;
      st_be   <= '0;
      st_data <= '0;
    end else begin
      unique case (state_q)
        SLOT_FREE: if (alloc) begin
          state_q <= SLOT_ISSUE;
          st_cmd  <= probe_cmd;
          st_addr <= probe_addr;
          st_be   <= probe_be;
        end
        SLOT_ISSUE: if (issue_ack) state_q <= SLOT_WAIT;
        SLOT_WAIT: if (cpl_hit) begin
          state_q <= SLOT_READY;
          st_data <= cpl_data;
          age_q   <= '0;
        end
        SLOT_READY: begin
          if (claim || expire) state_q <= SLOT_FREE;
          else                 age_q   <= age_q + 1'b1;
        end
        default: state_q <= SLOT_FREE;
      endcase
    end
  end

  // R7: a single issue moves the slot to waiting, never back to issuing
  p_single_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ack |=> (state_q == SLOT_WAIT) && !want_issue);

  // R10: a claim releases the slot for the next cycle
  p_claim_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> (state_q == SLOT_FREE));

  // R9: a completion not expected by this slot leaves its data untouched
  p_cpl_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_hit && state_q != SLOT_WAIT) |=> $stable(st_data));

  // R11: a completed slot never outlives its age window
  p_age_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (age_q < AGE_W'(AGE_LIMIT)));

endmodule

// File: rtl/drt_tracker.sv
module drt_tracker
  import drt_pkg::*;
#(
  parameter int NSLOT     = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BE_W      = 4,
  parameter int AGE_LIMIT = 1024,
  localparam int TAG_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLOT-1:0]  slot_en,
  input  logic              req_valid,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  output logic              resp_retry,
  output logic              resp_data_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              up_req_valid,
  input  logic              up_req_ready,
  output logic [TAG_W-1:0]  up_req_tag,
  output logic [3:0]        up_req_cmd,
  output logic [ADDR_W-1:0] up_req_addr,
  output logic [BE_W-1:0]   up_req_be,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic [DATA_W-1:0] cpl_data
);
  logic              req_ok, hit_any;
  logic [NSLOT-1:0]  busy_vec, want_vec, ready_vec, match_vec;
  logic [NSLOT-1:0]  free_en, alloc_grant, alloc_vec, claim_vec;
  logic [NSLOT-1:0]  issue_grant, issue_ack_vec, cpl_hit_vec;
  logic [3:0]        st_cmd  [NSLOT];
  logic [ADDR_W-1:0] st_addr [NSLOT];
  logic [BE_W-1:0]   st_be   [NSLOT];
  logic [DATA_W-1:0] st_data [NSLOT];

  assign req_ok    = req_valid && is_delayed_read(req_cmd);
  assign hit_any   = |match_vec;
  assign free_en   = ~busy_vec & slot_en;
  assign alloc_vec = (req_ok && !hit_any) ? alloc_grant : '0;
  assign claim_vec = req_ok ? (match_vec & ready_vec) : '0;

  assign resp_data_valid = |claim_vec;
  assign resp_retry      = req_ok && !resp_data_valid;

  assign up_req_valid  = |want_vec;
  assign issue_ack_vec = (up_req_valid && up_req_ready) ? issue_grant : '0;

  drt_prio #(.N(NSLOT)) u_alloc_pick (.req(free_en),  .grant(alloc_grant));
  drt_prio #(.N(NSLOT)) u_issue_pick (.req(want_vec), .grant(issue_grant));

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign cpl_hit_vec[i] = cpl_valid && (cpl_tag == TAG_W'(i));

    drt_slot #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .AGE_LIMIT(AGE_LIMIT)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (alloc_vec[i]),
      .claim      (claim_vec[i]),
      .issue_ack  (issue_ack_vec[i]),
      .cpl_hit    (cpl_hit_vec[i]),
      .cpl_data   (cpl_data),
      .probe_cmd  (req_cmd),
      .probe_addr (req_addr),
      .probe_be   (req_be),
      .busy       (busy_vec[i]),
      .want_issue (want_vec[i]),
      .ready      (ready_vec[i]),
      .match      (match_vec[i]),
      .st_cmd     (st_cmd[i]),
      .st_addr    (st_addr[i]),
      .st_be      (st_be[i]),
      .st_data    (st_data[i])
    );

    // R4: a slot only fills while its enable is set
    p_alloc_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_vec[i]) |-> $past(slot_en[i]));
  end

  // One-hot selects into the slot fields
  always_comb begin
    resp_data   = '0;
    up_req_tag  = '0;
    up_req_cmd  = '0;
    up_req_addr = '0;
    up_req_be   = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (claim_vec[i]) resp_data = resp_data | st_data[i];
      if (issue_grant[i]) begin
        up_req_tag  = up_req_tag  | TAG_W'(i);
        up_req_cmd  = up_req_cmd  | st_cmd[i];
        up_req_addr = up_req_addr | st_addr[i];
        up_req_be   = up_req_be   | st_be[i];
      end
    end
  end

  // R6: at most one slot holds any given request
  p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R8: retry and data are never given together
  p_resp_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_retry && resp_data_valid));

  // R8: a pending match is always retried
  p_pending_retry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ok && |(match_vec & ~ready_vec)) |-> resp_retry);

  // R2: unsupported commands get no answer
  p_unsupported_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_delayed_read(req_cmd)) |-> (!resp_retry && !resp_data_valid));

  // R5: a new read with no free enabled slot records nothing
  p_full_no_record_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ok && !hit_any && free_en == '0) |=> ((busy_vec & ~$past(busy_vec)) == '0));

endmodule

// File: tb/test_drt_tracker.sv
`timescale 1ns/1ps
module test_drt_tracker;
  localparam int NSLOT = 4, ADDR_W = 32, DATA_W = 32, BE_W = 4, AGE = 1024;
  localparam int TW = 2;

  // {cmd, expected retry} for an attempt with every slot disabled
  localparam logic [4:0] CMD_TAB [16] = '{
    5'b0000_0, 5'b0001_0, 5'b0010_1, 5'b0011_0,
    5'b0100_0, 5'b0101_0, 5'b0110_1, 5'b0111_0,
    5'b1000_0, 5'b1001_0, 5'b1010_0, 5'b1011_0,
    5'b1100_1, 5'b1101_0, 5'b1110_1, 5'b1111_0
  };
  localparam logic [3:0] IORD = 4'b0010, MRD = 4'b0110, MRM = 4'b1100, MRL = 4'b1110;

  logic clk = 0, rst_n = 0;
  logic [NSLOT-1:0] slot_en = '0;
  logic req_valid = 0;
  logic [3:0] req_cmd = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [BE_W-1:0] req_be = '0;
  logic resp_retry, resp_data_valid;
  logic [DATA_W-1:0] resp_data;
  logic up_req_valid, up_req_ready = 0;
  logic [TW-1:0] up_req_tag;
  logic [3:0] up_req_cmd;
  logic [ADDR_W-1:0] up_req_addr;
  logic [BE_W-1:0] up_req_be;
  logic cpl_valid = 0;
  logic [TW-1:0] cpl_tag = '0;
  logic [DATA_W-1:0] cpl_data = '0;

  always #2.5 clk = ~clk;

  drt_tracker #(.NSLOT(NSLOT), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W),
                .AGE_LIMIT(AGE)) i_drt_tracker (
    .clk, .rst_n, .slot_en, .req_valid, .req_cmd, .req_addr, .req_be,
    .resp_retry, .resp_data_valid, .resp_data, .up_req_valid, .up_req_ready,
    .up_req_tag, .up_req_cmd, .up_req_addr, .up_req_be,
    .cpl_valid, .cpl_tag, .cpl_data);

  int checks = 0, fails = 0, issue_cnt = 0;
  logic [TW-1:0] last_tag = '0;
  logic r_retry, r_ack;
  logic [DATA_W-1:0] r_data;

  always @(posedge clk)
    if (rst_n && up_req_valid && up_req_ready) begin
      issue_cnt <= issue_cnt + 1;
      last_tag  <= up_req_tag;
    end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic attempt(input logic [3:0] c, input logic [ADDR_W-1:0] a, input logic [BE_W-1:0] b);
    @(negedge clk);
    req_valid = 1; req_cmd = c; req_addr = a; req_be = b;
    #1;
    r_retry = resp_retry; r_ack = resp_data_valid; r_data = resp_data;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic complete(input logic [TW-1:0] t, input logic [DATA_W-1:0] d);
    @(negedge clk);
    cpl_valid = 1; cpl_tag = t; cpl_data = d;
    @(negedge clk);
    cpl_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int c0;
    idle(3);
    rst_n = 1;
    #1;
    chk(!resp_retry && !resp_data_valid && !up_req_valid, "R1 reset idle",
        {resp_retry, resp_data_valid, up_req_valid}, 0);

    // R2 / R5: command table with every slot disabled
    for (int k = 0; k < 16; k++) begin
      attempt(CMD_TAB[k][4:1], 32'h100 + k, 4'hF);
      chk(r_retry == CMD_TAB[k][0] && !r_ack, "R2 command claim",
          {r_retry, r_ack}, {CMD_TAB[k][0], 1'b0});
    end
    idle(2); #1;
    chk(!up_req_valid && issue_cnt == 0, "R5 nothing recorded when no slot enabled",
        issue_cnt, 0);

    // R3 / R4 / R7: slots 1 and 3 enabled, upstream stalled
    slot_en = 4'b1010;
    attempt(MRD, 32'h1000, 4'hF);
    chk(r_retry && !r_ack, "R3 first attempt retried", r_retry, 1);
    #1;
    chk(up_req_valid && up_req_tag == 1, "R4 lowest enabled slot used", up_req_tag, 1);
    chk(up_req_cmd == MRD && up_req_addr == 32'h1000 && up_req_be == 4'hF,
        "R7 upstream fields", up_req_addr, 32'h1000);
    attempt(MRL, 32'h2000, 4'h3);
    #1;
    chk(up_req_valid && up_req_tag == 1, "R7 lowest index issued first", up_req_tag, 1);
    attempt(MRM, 32'h3000, 4'hF);
    chk(r_retry && !r_ack, "R5 full tracker retries", r_retry, 1);
    attempt(MRD, 32'h1000, 4'hF);
    chk(r_retry && !r_ack, "R8 pending repeat retried", {r_retry, r_ack}, 2'b10);

    up_req_ready = 1;
    idle(4); #1;
    chk(issue_cnt == 2 && !up_req_valid, "R7 one issue per slot, R5 none for rejected",
        issue_cnt, 2);
    attempt(MRD, 32'h1000, 4'hF);
    chk(r_retry && !r_ack, "R8 outstanding repeat retried", {r_retry, r_ack}, 2'b10);

    // R9: completions
    complete(0, 32'hBAD0BAD0);
    complete(1, 32'hDEADBEEF);
    complete(1, 32'h12345678);

    // R6: near misses
    attempt(MRD, 32'h1000, 4'hE);
    chk(r_retry && !r_ack, "R6 byte enable differs", {r_retry, r_ack}, 2'b10);
    attempt(MRD, 32'h1004, 4'hF);
    chk(r_retry && !r_ack, "R6 address differs", {r_retry, r_ack}, 2'b10);
    attempt(IORD, 32'h1000, 4'hF);
    chk(r_retry && !r_ack, "R6 command differs", {r_retry, r_ack}, 2'b10);

    attempt(MRD, 32'h1000, 4'hF);
    chk(r_ack && !r_retry, "R10 completed repeat gets data", {r_retry, r_ack}, 2'b01);
    chk(r_data == 32'hDEADBEEF, "R9 stored data, later completion ignored",
        r_data, 32'hDEADBEEF);
    c0 = issue_cnt;
    attempt(MRD, 32'h1000, 4'hF);
    chk(r_retry && !r_ack, "R10 slot freed, new request", {r_retry, r_ack}, 2'b10);
    idle(2);
    chk(issue_cnt == c0 + 1 && last_tag == 1, "R10 reissued from slot 1",
        issue_cnt, c0 + 1);

    // R11: claim inside the window
    complete(3, 32'hCAFEF00D);
    idle(1000);
    attempt(MRL, 32'h2000, 4'h3);
    chk(r_ack && r_data == 32'hCAFEF00D, "R11 claim before expiry", r_data, 32'hCAFEF00D);

    // R11: expiry
    attempt(MRL, 32'h2000, 4'h3);
    idle(2);
    complete(3, 32'h55AA55AA);
    idle(AGE + 6);
    c0 = issue_cnt;
    attempt(MRL, 32'h2000, 4'h3);
    chk(r_retry && !r_ack, "R11 expired slot treated as new", {r_retry, r_ack}, 2'b10);
    idle(2);
    chk(issue_cnt == c0 + 1 && last_tag == 3, "R11 new upstream read after expiry",
        issue_cnt, c0 + 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule